// File: doc/BRIEF.md
# Edge-Rephased Oversampling Bit Sampler

This block recovers the bits of an asynchronous serial line. A clock enable marks sixteen sampling instants per nominal bit time. The line idles high. A falling edge from idle marks the start of a frame, and that edge sets the phase of a cell counter. Every data bit is then read once, at the centre of its cell.

A line whose rate differs from the receiver's drifts against the counter. The block corrects this at each transition inside the frame: any data edge that falls close to the expected cell boundary resets the counter phase. An alternating stream can therefore be far off the nominal rate and still be read correctly. Edges far from a boundary are treated as noise and do not touch the phase.

The number of data bits is a parameter. After the last data bit the block samples one stop bit and reports the end of the frame, with a flag if the stop bit was low. Parity checking, storage of the received word and any host access are left to the surrounding logic.

Top module: `serial_cell_sampler`

## Requirements
- R1: While reset is asserted and after it is released with the line idle high, `bit_stb`, `frame_done`, `frame_err` and `bit_out` are all low, and no strobe appears until a falling edge arrives.
- R2: The line passes through a two-flop synchronizer. A high-to-low transition seen in idle starts a frame, and the tick that sees it is count 0 of the start cell.
- R3: The start bit is re-read at count 8 of its cell. If the line is high there, the frame is abandoned with no `bit_stb` and no `frame_done`.
- R4: Each frame delivers exactly DATA_BITS `bit_stb` pulses. Each pulse carries the line value at count 8 of its cell on `bit_out`, in the order the bits arrive. The bench assembles the first bit as the least significant.
- R5: The stop bit is read at count 8 of the cell after the last data bit. `frame_done` then pulses for one clock, and `frame_err` is high in that same clock exactly when the stop bit read low. `frame_err` is never high without `frame_done`.
- R6: A line transition seen within 4 counts of the expected cell boundary makes that tick count 0 of a cell. The transition may be up to 4 counts before the boundary or up to 4 counts after it. An edge on the early side also advances to the next cell. As a result, an alternating stream with 14, 17 or 18 clocks per bit, at one enable per clock, is decoded correctly.
- R7: A transition that lands more than 4 counts from a cell boundary leaves the phase unchanged.
- R8: The counter and the state advance only on clocks where `os_en` is high. A strobe is only raised in the clock after an enabled one, so a half-rate enable with 32 clocks per bit decodes like 16.
- R9: `bit_stb` is never high in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_en | input | 1 | Oversampling enable, OVS pulses per nominal bit |
| line_in | input | 1 | Raw asynchronous serial line, idle high |
| bit_out | output | 1 | Most recently sampled data bit |
| bit_stb | output | 1 | One-clock pulse: `bit_out` holds a new data bit |
| frame_done | output | 1 | One-clock pulse after the stop bit has been sampled |
| frame_err | output | 1 | High with `frame_done` when the stop bit read low |

## Verification
The bound checker watches, on every clock, the pulse shape of the strobes and the pairing of the error flag with frame completion. It also checks that strobes only follow enabled clocks, and it counts the data strobes of each frame to confirm that exactly DATA_BITS precede `frame_done`. Whether the right values are sampled can only be shown by the bench scenarios. These cover the centre-of-cell reads, glitch rejection of a short start pulse, and phase recovery on alternating streams sent 12% fast or slow. They also cover immunity to a mid-cell spike and decoding under a gapped enable, where correctness depends on where the line sits relative to the counter.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/ovs_line_sync.sv
module ovs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_in,
  output logic line_s,
  output logic fall,
  output logic toggle
);
  logic [STAGES-1:0] stage_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b1;
        else        stage_q[g] <= line_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b1;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign line_s = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= 1'b1;
    else if (tick) last_q <= line_s;
  end

  assign fall   = tick && last_q && !line_s;
  assign toggle = tick && (last_q != line_s);
endmodule

// File: rtl/ovs_phase_ctr.sv
module ovs_phase_ctr #(
  parameter int OVS = 16,
  parameter int WIN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   run,
  input  logic                   start,
  input  logic                   toggle,
  output logic [$clog2(OVS)-1:0] cnt,
  output logic                   at_mid,
  output logic                   at_end
);
  localparam int CW    = $clog2(OVS);
  localparam int MID   = OVS / 2;
  localparam int LAST  = OVS - 1;
  localparam int EARLY = OVS - WIN;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          early, late;

  always_comb begin
    early  = run && toggle && (cnt_q >= CW'(EARLY));
    late   = run && toggle && (cnt_q <= CW'(WIN));
    at_mid = run && tick && (cnt_q == CW'(MID));
    at_end = run && tick && ((cnt_q == CW'(LAST)) || early);
    cnt_d  = cnt_q;
    if (tick) begin
      if (!run)                cnt_d = start ? CW'(1) : '0;
      else if (early || late)  cnt_d = CW'(1);
      else if (cnt_q == CW'(LAST)) cnt_d = '0;
      else                     cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ovs_frame_fsm.sv
module ovs_frame_fsm
  import ovs_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic line_s,
  input  logic at_mid,
  input  logic at_end,
  output logic busy,
  output logic bit_out,
  output logic bit_stb,
  output logic frame_done,
  output logic frame_err
);
  localparam int IW = $clog2(DATA_BITS + 1);

  rx_state_t     state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          bit_q, bit_d;
  logic          stb_d, done_d, err_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    bit_d   = bit_q;
    stb_d   = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall) begin
          state_d = ST_START;
          idx_d   = '0;
        end
      end
      ST_START: begin
        if (at_mid && line_s) state_d = ST_IDLE;
        else if (at_end)      state_d = ST_DATA;
      end
      ST_DATA: begin
        if (at_mid) begin
          stb_d = 1'b1;
          bit_d = line_s;
          idx_d = idx_q + IW'(1);
        end else if (at_end && (idx_q == IW'(DATA_BITS))) begin
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (at_mid) begin
          done_d  = 1'b1;
          err_d   = !line_s;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      bit_q      <= 1'b0;
      bit_stb    <= 1'b0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      state_q    <= state_d;
      idx_q      <= idx_d;
      bit_q      <= bit_d;
      bit_stb    <= stb_d;
      frame_done <= done_d;
      frame_err  <= err_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign bit_out = bit_q;
endmodule

// File: rtl/serial_cell_sampler.sv
module serial_cell_sampler #(
  parameter int OVS         = 16,
  parameter int DATA_BITS   = 8,
  parameter int RESYNC_WIN  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_en,
  input  logic line_in,
  output logic bit_out,
  output logic bit_stb,
  output logic frame_done,
  output logic frame_err
);
  localparam int CW = $clog2(OVS);

  logic          line_s, fall, toggle;
  logic          busy, at_mid, at_end, start;
  logic [CW-1:0] ph_cnt;

  ovs_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (os_en),
    .line_in(line_in),
    .line_s (line_s),
    .fall   (fall),
    .toggle (toggle)
  );

  assign start = fall && !busy;

  ovs_phase_ctr #(.OVS(OVS), .WIN(RESYNC_WIN)) i_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (os_en),
    .run    (busy),
    .start  (start),
    .toggle (toggle),
    .cnt    (ph_cnt),
    .at_mid (at_mid),
    .at_end (at_end)
  );

  ovs_frame_fsm #(.DATA_BITS(DATA_BITS)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall      (fall),
    .line_s    (line_s),
    .at_mid    (at_mid),
    .at_end    (at_end),
    .busy      (busy),
    .bit_out   (bit_out),
    .bit_stb   (bit_stb),
    .frame_done(frame_done),
    .frame_err (frame_err)
  );
endmodule

// File: rtl/ovs_sampler_checker.sv
module ovs_sampler_checker #(
  parameter int DATA_BITS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic os_en,
  input logic busy,
  input logic bit_stb,
  input logic frame_done,
  input logic frame_err
);
  localparam int NW = $clog2(DATA_BITS + 2);

  logic [NW-1:0] nbits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     nbits_q <= '0;
    else if (!busy) nbits_q <= '0;
    else if (bit_stb && nbits_q <= NW'(DATA_BITS)) nbits_q <= nbits_q + NW'(1);
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) bit_stb |=> !bit_stb); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> !frame_done); // R5
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) frame_err |-> frame_done); // R5
  AST_STB_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n) bit_stb |-> $past(os_en)); // R8
  AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n) frame_done |-> $past(os_en)); // R8
  AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) nbits_q <= NW'(DATA_BITS)); // R4
  AST_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n) frame_done |-> (nbits_q == NW'(DATA_BITS))); // R4
endmodule

bind serial_cell_sampler ovs_sampler_checker #(.DATA_BITS(DATA_BITS)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .os_en     (os_en),
  .busy      (busy),
  .bit_stb   (bit_stb),
  .frame_done(frame_done),
  .frame_err (frame_err)
);

// File: tb/test_serial_cell_sampler.sv
module test_serial_cell_sampler;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {data[7:0], clocks per bit[5:0], stop level}
  localparam logic [14:0] VECS [NVEC] = '{
    {8'hA5, 6'd16, 1'b1},
    {8'h00, 6'd16, 1'b1},
    {8'hFF, 6'd16, 1'b1},
    {8'h55, 6'd14, 1'b1},
    {8'h55, 6'd18, 1'b1},
    {8'h3C, 6'd16, 1'b0},
    {8'hAA, 6'd17, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_en = 1'b1;
  logic line_in = 1'b1;
  logic half_rate = 1'b0;
  logic bit_out, bit_stb, frame_done, frame_err;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] rx_byte = '0;
  int rx_n = 0;
  int done_n = 0;
  logic last_err = 1'b0;
  logic prev_stb = 1'b0;
  int wide_stb = 0;

  serial_cell_sampler i_serial_cell_sampler (
    .clk(clk), .rst_n(rst_n), .os_en(os_en), .line_in(line_in),
    .bit_out(bit_out), .bit_stb(bit_stb),
    .frame_done(frame_done), .frame_err(frame_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) os_en <= half_rate ? ~os_en : 1'b1;

  always @(negedge clk) begin
    if (bit_stb) begin
      rx_byte = {bit_out, rx_byte[7:1]};
      rx_n++;
    end
    if (frame_done) begin
      done_n++;
      last_err = frame_err;
    end
    if (bit_stb && prev_stb) wide_stb++;
    prev_stb = bit_stb;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_rx();
    rx_byte = '0;
    rx_n = 0;
    done_n = 0;
    last_err = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input int per, input logic stopb,
                            input int sp_cell, input int sp_off);
    for (int c = 0; c < 10; c++) begin
      logic v;
      v = (c == 0) ? 1'b0 : (c == 9) ? stopb : d[c-1];
      for (int k = 0; k < per; k++) begin
        @(negedge clk);
        line_in = (c == sp_cell && (k == sp_off || k == sp_off + 1)) ? ~v : v;
      end
    end
    @(negedge clk);
    line_in = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    chk(!bit_stb && !frame_done && !frame_err && !bit_out, "R1 reset",
        {bit_out, bit_stb, frame_done, frame_err}, 0);
    rst_n = 1'b1;
    clear_rx();
    repeat (60) @(negedge clk);
    chk(rx_n == 0, "R1 idle bits", rx_n, 0);
    chk(done_n == 0, "R1 idle done", done_n, 0);
    chk(!bit_out && !frame_err, "R1 idle outputs", {bit_out, frame_err}, 0);

    // Vector table: R4, R5, R6
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] d;
      int per;
      logic sb;
      d = VECS[i][14:7];
      per = int'(VECS[i][6:1]);
      sb = VECS[i][0];
      clear_rx();
      send_frame(d, per, sb, 99, 0);
      chk(rx_byte == d, (per == 16) ? "R4 data" : "R6 data", rx_byte, d);
      chk(rx_n == 8, "R4 bit count", rx_n, 8);
      chk(done_n == 1 && last_err == !sb, "R5 stop/error", {done_n[3:0], last_err}, {4'd1, !sb});
    end

    // R3: short low pulse is rejected
    clear_rx();
    repeat (4) begin @(negedge clk); line_in = 1'b0; end
    @(negedge clk); line_in = 1'b1;
    repeat (60) @(negedge clk);
    chk(rx_n == 0, "R3 glitch bits", rx_n, 0);
    chk(done_n == 0, "R3 glitch done", done_n, 0);

    // R2: a real frame right after the glitch
    clear_rx();
    send_frame(8'h96, 16, 1'b1, 99, 0);
    chk(rx_byte == 8'h96, "R2 frame after glitch", rx_byte, 8'h96);
    chk(done_n == 1 && !last_err, "R2 done", done_n, 1);

    // R7: spike at counts 5..6 of data bit 2 leaves phase alone
    clear_rx();
    send_frame(8'hF0, 16, 1'b1, 3, 5);
    chk(rx_byte == 8'hF0, "R7 data", rx_byte, 8'hF0);
    chk(rx_n == 8, "R7 bit count", rx_n, 8);
    chk(done_n == 1 && !last_err, "R7 stop", {done_n[3:0], last_err}, {4'd1, 1'b0});

    // R8: half-rate enable, 32 clocks per bit
    half_rate = 1'b1;
    repeat (4) @(negedge clk);
    clear_rx();
    send_frame(8'hC3, 32, 1'b1, 99, 0);
    chk(rx_byte == 8'hC3, "R8 data", rx_byte, 8'hC3);
    chk(rx_n == 8, "R8 bit count", rx_n, 8);
    chk(done_n == 1 && !last_err, "R8 stop", done_n, 1);
    half_rate = 1'b0;
    repeat (4) @(negedge clk);

    // R9: no strobe ever lasted two clocks
    chk(wide_stb == 0, "R9 strobe width", wide_stb, 0);

    finished = 1'b1;
    summary();
  end
endmodule